// File: doc/BRIEF.md
# Banked Multi-Port Register File

This block is a 256-entry register file built from eight independent banks. Each bank has 32 words, one read port and one write port. Four functional-unit requesters can each ask for one register per cycle. Registers are spread across the banks in round-robin order, so a run of consecutive register numbers lands in different banks and every request in such a run is served in the same cycle.

A per-bank arbiter looks at all live requests aimed at its bank. When several requesters name the same register, the bank performs one read and returns the word to all of them. When they name different words in the same bank, the bank serves one word per cycle, lowest requester index first. Each requester holds `rd_req` high, with a steady address, until it sees a one-cycle `rd_valid` pulse.

Each requester has a small state machine with three states:
- `RQ_READY`: the requester is idle or has just raised a request.
- `RQ_WAIT`: the requester lost arbitration and is retrying.
- `RQ_DELIVER`: data is on the port this cycle.

The transitions are as follows:
- *grant*: `RQ_READY` or `RQ_WAIT` moves to `RQ_DELIVER`.
- *stall*: `RQ_READY` or `RQ_WAIT` moves to `RQ_WAIT` when the request is held but not granted.
- *drop*: `RQ_READY` or `RQ_WAIT` moves to `RQ_READY` when there is no request.
- *retire*: `RQ_DELIVER` always moves to `RQ_READY`.

A single write port stores one word per cycle, independently of the reads.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every bit of `rd_valid` is 0.
- R2: Register number `a` (8 bits) lives in bank `a[2:0]` at word `a[7:3]`. A write to `a` (`wr_en` high at a rising edge) is returned by any later read of `a`.
- R3: A request that is live at a rising edge and is granted produces `rd_valid` high, with the register's data on that requester's 32-bit slice of `rd_data` (requester `i` uses bits `32*i+31:32*i`), right after that edge. `rd_valid` is never raised without a request in the previous cycle.
- R4: Requests that fall in pairwise different banks are all served in the same cycle.
- R5: Requesters that are live in the same cycle and name the same register are served together from one bank read.
- R6: Live requesters that name different words of the same bank are served one per cycle, in ascending requester index.
- R7: `rd_valid` for a requester is a single-cycle pulse. The request and address presented in the cycle where `rd_valid` is high are ignored, so a new request is first considered one cycle later.
- R8: A read and a write to the same register at the same edge return the data held before that write.
- R9: A live request from requester 0 is always served at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Register number to write |
| wr_data | input | 32 | Write data |
| rd_req | input | 4 | Per-requester read request, held until its `rd_valid` pulse |
| rd_addr | input | 32 | Four packed 8-bit register numbers, requester `i` at bits `8*i+7:8*i` |
| rd_valid | output | 4 | Per-requester one-cycle data-valid pulse |
| rd_data | output | 128 | Four packed 32-bit read words |

## Verification
The bench drives four requesters from address queues and runs them against a behavioural model of banks, priority and broadcast:
- Consecutive register numbers must all return in one cycle. A wrong bank mapping serializes these reads or returns words from the wrong bank.
- A four-way same-register request must finish in one cycle. Broken broadcast serializes it.
- A four-way same-bank conflict must drain in index order over four cycles. Broken priority reorders it.
- A read that meets a write to the same word must return the old value. A write-through path returns the new one.
- Back-to-back requests from one requester check that the request seen during its valid cycle is not served twice.
- Random mixed traffic covers the remaining interleavings.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic [1:0] {
        RQ_READY   = 2'd0,
        RQ_WAIT    = 2'd1,
        RQ_DELIVER = 2'd2
    } rq_state_e;

endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int DW    = 32,
    parameter int WORDS = 32,
    localparam int WW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [WW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [WW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [WORDS];

    // Write and read at one edge: the read samples the old word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/rf_bank_arb.sv
module rf_bank_arb #(
    parameter int NREQ    = 4,
    parameter int BW      = 3,
    parameter int WW      = 5,
    parameter int BANK_ID = 0,
    localparam int AW     = BW + WW
) (
    input  logic [NREQ-1:0]    active,
    input  logic [NREQ*AW-1:0] addr,
    output logic               ren,
    output logic [WW-1:0]      rword,
    output logic [NREQ-1:0]    grant
);

    localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

    logic          found;
    logic [AW-1:0] win_addr;

    always_comb begin
        found    = 1'b0;
        win_addr = '0;
        // Lowest index that targets this bank wins.
        for (int i = 0; i < NREQ; i++) begin
            if (!found && active[i] && addr[i*AW +: BW] == MY_BANK) begin
                found    = 1'b1;
                win_addr = addr[i*AW +: AW];
            end
        end
        ren   = found;
        rword = win_addr[AW-1:BW];
        // Everyone naming the winning register shares the one read.
        for (int i = 0; i < NREQ; i++) begin
            grant[i] = found && active[i] && (addr[i*AW +: AW] == win_addr);
        end
    end

endmodule

// File: rtl/rf_req_fsm.sv
module rf_req_fsm
    import rf_pkg::*;
#(
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          grant,
    input  logic [BW-1:0] bank_in,
    output logic          active,
    output logic          valid,
    output logic [BW-1:0] bank_sel
);

    rq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_READY, RQ_WAIT: begin
                if (req && grant)  state_d = RQ_DELIVER;
                else if (req)      state_d = RQ_WAIT;
                else               state_d = RQ_READY;
            end
            RQ_DELIVER:            state_d = RQ_READY;
            default:               state_d = RQ_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RQ_READY;
            bank_sel <= '0;
        end else begin
            state_q <= state_d;
            if (grant) begin
                bank_sel <= bank_in;
            end
        end
    end

    always_comb begin
        active = req && (state_q != RQ_DELIVER);
        valid  = (state_q == RQ_DELIVER);
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
    parameter int DW    = 32,
    parameter int NBANK = 8,
    parameter int WORDS = 32,
    parameter int NREQ  = 4,
    localparam int BW   = $clog2(NBANK),
    localparam int WW   = $clog2(WORDS),
    localparam int AW   = BW + WW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [NREQ-1:0]    rd_req,
    input  logic [NREQ*AW-1:0] rd_addr,
    output logic [NREQ-1:0]    rd_valid,
    output logic [NREQ*DW-1:0] rd_data
);

    logic [NREQ-1:0] active;
    logic [NREQ-1:0] grant;
    logic [NREQ-1:0] bank_grant [NBANK];
    logic [DW-1:0]   bank_rdata [NBANK];
    logic [BW-1:0]   sel_q      [NREQ];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic          ren;
        logic [WW-1:0] rword;

        rf_bank_arb #(.NREQ(NREQ), .BW(BW), .WW(WW), .BANK_ID(b)) u_arb (
            .active (active),
            .addr   (rd_addr),
            .ren    (ren),
            .rword  (rword),
            .grant  (bank_grant[b])
        );

        rf_bank #(.DW(DW), .WORDS(WORDS)) u_bank (
            .clk   (clk),
            .we    (wr_en && (wr_addr[BW-1:0] == BW'(b))),
            .waddr (wr_addr[AW-1:BW]),
            .wdata (wr_data),
            .re    (ren),
            .raddr (rword),
            .rdata (bank_rdata[b])
        );
    end

    always_comb begin
        grant = '0;
        for (int b = 0; b < NBANK; b++) begin
            grant = grant | bank_grant[b];
        end
    end

    for (genvar i = 0; i < NREQ; i++) begin : g_req
        rf_req_fsm #(.BW(BW)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (rd_req[i]),
            .grant    (grant[i]),
            .bank_in  (rd_addr[i*AW +: BW]),
            .active   (active[i]),
            .valid    (rd_valid[i]),
            .bank_sel (sel_q[i])
        );
        assign rd_data[i*DW +: DW] = bank_rdata[sel_q[i]];
    end

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int NREQ = 4,
    parameter int BW   = 3,
    parameter int AW   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NREQ-1:0]    rd_req,
    input logic [NREQ*AW-1:0] rd_addr,
    input logic [NREQ-1:0]    rd_valid
);

    logic [NREQ-1:0] live;
    logic            all_apart;

    always_comb begin
        live      = rd_req & ~rd_valid;
        all_apart = &live;
        for (int i = 0; i < NREQ; i++) begin
            for (int j = i + 1; j < NREQ; j++) begin
                if (rd_addr[i*AW +: BW] == rd_addr[j*AW +: BW]) all_apart = 1'b0;
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_valid == '0));

    assert_spread_banks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        all_apart |=> (&rd_valid));

    assert_top_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        live[0] |=> rd_valid[0]);

    for (genvar i = 0; i < NREQ; i++) begin : g_one
        assert_valid_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid[i] |-> $past(rd_req[i]));

        assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid[i] |=> !rd_valid[i]);

        for (genvar j = i + 1; j < NREQ; j++) begin : g_pair
            assert_broadcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (live[i] && live[j] && rd_addr[i*AW +: AW] == rd_addr[j*AW +: AW])
                |=> (rd_valid[i] == rd_valid[j]));

            assert_serialize_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (live[i] && live[j] && rd_addr[i*AW +: BW] == rd_addr[j*AW +: BW]
                 && rd_addr[i*AW +: AW] != rd_addr[j*AW +: AW])
                |=> !(rd_valid[i] && rd_valid[j]));
        end
    end

endmodule

bind banked_regfile rf_checker #(.NREQ(NREQ), .BW(BW), .AW(AW)) u_rf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid)
);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;

    localparam int NREQ = 4;
    localparam int DW   = 32;
    localparam int AW   = 8;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               wr_en;
    logic [AW-1:0]      wr_addr;
    logic [DW-1:0]      wr_data;
    logic [NREQ-1:0]    rd_req;
    logic [NREQ*AW-1:0] rd_addr;
    logic [NREQ-1:0]    rd_valid;
    logic [NREQ*DW-1:0] rd_data;

    always #4 clk = ~clk;

    banked_regfile dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    logic [AW-1:0]   rq [NREQ][$];
    logic [39:0]     wq [$];
    logic [DW-1:0]   model_mem [256];
    logic [NREQ-1:0] exp_valid = '0;
    logic [DW-1:0]   exp_data [NREQ];

    function automatic logic [DW-1:0] seed_word(input logic [7:0] a);
        return {a, ~a, a ^ 8'h3c, a + 8'd7};
    endfunction

    task automatic step();
        logic [NREQ-1:0] act;
        logic [NREQ-1:0] nv;
        @(negedge clk);
        checks++;
        if (rd_valid !== exp_valid) begin
            fails++;
            $display("FAIL %s rd_valid actual %b expected %b", tag, rd_valid, exp_valid);
        end
        for (int i = 0; i < NREQ; i++) begin
            if (exp_valid[i]) begin
                checks++;
                if (rd_data[i*DW +: DW] !== exp_data[i]) begin
                    fails++;
                    $display("FAIL %s rd_data[%0d] actual %h expected %h",
                             tag, i, rd_data[i*DW +: DW], exp_data[i]);
                end
                if (rq[i].size() > 0) void'(rq[i].pop_front());
            end
        end
        for (int i = 0; i < NREQ; i++) begin
            rd_req[i]           = (rq[i].size() > 0);
            rd_addr[i*AW +: AW] = (rq[i].size() > 0) ? rq[i][0] : '0;
        end
        if (wq.size() > 0) begin
            logic [39:0] w;
            w       = wq.pop_front();
            wr_en   = 1'b1;
            wr_addr = w[39:32];
            wr_data = w[31:0];
        end else begin
            wr_en = 1'b0;
        end
        // Behavioural expectation for the next edge.
        act = rd_req & ~exp_valid;
        nv  = '0;
        for (int b = 0; b < 8; b++) begin
            int win;
            win = -1;
            for (int i = 0; i < NREQ; i++)
                if (win < 0 && act[i] && (rd_addr[i*AW +: AW] % 8) == b) win = i;
            if (win >= 0) begin
                for (int i = 0; i < NREQ; i++) begin
                    if (act[i] && rd_addr[i*AW +: AW] == rd_addr[win*AW +: AW]) begin
                        nv[i]       = 1'b1;
                        exp_data[i] = model_mem[rd_addr[i*AW +: AW]];
                    end
                end
            end
        end
        if (wr_en) model_mem[wr_addr] = wr_data;
        exp_valid = nv;
    endtask

    task automatic drain();
        int guard = 0;
        while ((wq.size() > 0 || exp_valid != '0 || rq[0].size() > 0 || rq[1].size() > 0
                || rq[2].size() > 0 || rq[3].size() > 0) && guard < 2000) begin
            step();
            guard++;
        end
        step();
    endtask

    task automatic push4(input logic [7:0] a0, input logic [7:0] a1,
                         input logic [7:0] a2, input logic [7:0] a3);
        rq[0].push_back(a0); rq[1].push_back(a1);
        rq[2].push_back(a2); rq[3].push_back(a3);
    endtask

    initial begin
        #1_200_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_req = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (rd_valid !== '0) begin
            fails++;
            $display("FAIL R1 reset rd_valid actual %b expected 0000", rd_valid);
        end
        rst_n = 1'b1;
        tag = "R1"; step();

        tag = "R2";
        for (int a = 0; a < 256; a++) wq.push_back({8'(a), seed_word(8'(a))});
        drain();
        push4(8'd0, 8'd255, 8'd129, 8'd66);
        drain();

        tag = "R4"; push4(8'd8, 8'd9, 8'd10, 8'd11); drain();
        tag = "R4"; push4(8'd23, 8'd20, 8'd22, 8'd21); drain();
        tag = "R5"; push4(8'd37, 8'd37, 8'd37, 8'd37); drain();
        tag = "R6/R9"; push4(8'd27, 8'd19, 8'd11, 8'd3); drain();
        tag = "R5/R6"; push4(8'd5, 8'd5, 8'd13, 8'd6); drain();

        tag = "R8";
        wq.push_back({8'd42, 32'hdead_beef});
        rq[1].push_back(8'd42);
        drain();
        rq[2].push_back(8'd42);
        drain();

        tag = "R7";
        rq[2].push_back(8'd14); rq[2].push_back(8'd15); rq[2].push_back(8'd14);
        rq[0].push_back(8'd6);  rq[0].push_back(8'd7);
        drain();

        tag = "R3";
        for (int k = 0; k < 600; k++) begin
            for (int i = 0; i < NREQ; i++)
                if (rq[i].size() == 0 && ($urandom % 2) == 0) rq[i].push_back(8'($urandom % 32));
            if (($urandom % 3) == 0 && wq.size() == 0)
                wq.push_back({8'($urandom % 32), 32'($urandom)});
            step();
        end
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule